// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses, in the fetch stage, whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a short register of recent branch outcomes. The fetch address is folded with that outcome history to select one counter. The counter's upper bit gives the guess in the same cycle that the address is presented. The selected index is also driven out, so the pipeline can carry it along with the branch.

When the branch resolves in a later stage, the pipeline returns an update. The update carries a valid strobe, a flag that marks a conditional branch, the real outcome, and the index recorded at fetch. The counter at that index moves one step toward the outcome. The outcome is shifted into the history. Updates for anything other than a conditional branch leave the predictor untouched.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history holds zero. Every fetch address therefore predicts not taken.
- R2: `pred_idx` equals `fetch_pc[7:2]` XOR the 6-bit history. It follows the inputs within the same cycle.
- R3: `pred_taken` is bit 1 (the upper bit) of the counter selected by `pred_idx`. It is valid in the same cycle as `fetch_pc`.
- R4: A conditional update with `upd_taken`=1 increments the counter at `upd_idx`. A counter already at 11 stays at 11.
- R5: A conditional update with `upd_taken`=0 decrements the counter at `upd_idx`. A counter already at 00 stays at 00.
- R6: An update writes only the entry named by `upd_idx`, whatever the current fetch address and history select.
- R7: Each conditional update shifts `upd_taken` into history bit 0 and moves the older bits up one place. The oldest bit is dropped.
- R8: A cycle with `upd_valid`=0, or with `upd_cond`=0, changes neither the table nor the history.
- R9: An update presented in cycle N affects predictions from cycle N+1 onward. A prediction made in cycle N uses the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| pred_taken | output | 1 | Guess for this fetch: 1 means taken |
| pred_idx | output | 6 | Table index used for this guess |
| upd_valid | input | 1 | A resolved instruction is reported this cycle |
| upd_cond | input | 1 | The reported instruction is a conditional branch |
| upd_taken | input | 1 | Real outcome of the reported branch |
| upd_idx | input | 6 | Index that was used when the branch was fetched |

## Verification
Both outputs are combinational from `fetch_pc` and the stored state, so each guess and index is due in the same cycle the address is driven. The bench drives inputs on the falling edge and compares 8 ns later, just before the next rising edge. An update changes the counters and the history at the rising edge that closes its cycle, so it first shows in the expectation queued for the following cycle. The bench's reference model applies each update only after queuing that cycle's expected prediction, which reproduces this one-cycle delay, including for a fetch that hits the entry being updated.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;

    typedef struct packed {
        ctr_t cnt;
    } entry_st_t;

    // one saturating step toward the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != 2'b11)
            nxt = cur + 2'b01;
        else if (!taken && cur != 2'b00)
            nxt = cur - 2'b01;
        return nxt;
    endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] pc_bits,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = pc_bits ^ hist;
    end
endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_q
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en)
            st_d.bits = {st_q.bits[HIST_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign hist_q = st_q.bits;
endmodule

// File: rtl/gshare_table.sv
module gshare_table
    import gshare_pkg::*;
#(
    parameter int IDX_W   = 6,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_taken,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_taken,
    output logic [ENTRIES-1:0][1:0] ctr_all
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        entry_st_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_idx == IDX_W'(e))
                ent_d.cnt = ctr_step(ent_q.cnt, wr_taken);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q <= '{cnt: CTR_RESET};
            else
                ent_q <= ent_d;
        end

        assign ctr_all[e] = ent_q.cnt;
    end

    assign rd_taken = ctr_all[rd_idx][1];
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 6,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_idx,
    input  logic             upd_valid,
    input  logic             upd_cond,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_idx
);
    logic [IDX_W-1:0]        hist_q;
    logic [ENTRIES-1:0][1:0] ctr_all;
    logic                    upd_fire;
    logic                    pc_unused;

    assign upd_fire  = upd_valid & upd_cond;
    assign pc_unused = ^{fetch_pc[PC_W-1:PC_LSB+IDX_W], fetch_pc[PC_LSB-1:0]};

    gshare_index #(.IDX_W(IDX_W)) u_index (
        .pc_bits (fetch_pc[PC_LSB +: IDX_W]),
        .hist    (hist_q),
        .idx     (pred_idx)
    );

    gshare_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_fire),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .ctr_all  (ctr_all)
    );

    gshare_history #(.HIST_W(IDX_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_fire),
        .bit_in   (upd_taken),
        .hist_q   (hist_q)
    );
endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
    parameter int IDX_W = 6,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    upd_valid,
    input logic                    upd_cond,
    input logic                    upd_taken,
    input logic [IDX_W-1:0]        upd_idx,
    input logic [IDX_W-1:0]        pred_idx,
    input logic                    pred_taken,
    input logic [IDX_W-1:0]        hist,
    input logic [ENTRIES-1:0][1:0] ctrs
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hist == '0 && ctrs == {ENTRIES{2'b01}}));

    a_r3_pred_bit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == ctrs[pred_idx][1]);

    a_r4_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_cond && upd_taken) |=>
        ctrs[$past(upd_idx)] == (($past(ctrs[upd_idx]) == 2'b11) ? 2'b11
                                 : 2'($past(ctrs[upd_idx]) + 2'b01)));

    a_r5_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_cond && !upd_taken) |=>
        ctrs[$past(upd_idx)] == (($past(ctrs[upd_idx]) == 2'b00) ? 2'b00
                                 : 2'($past(ctrs[upd_idx]) - 2'b01)));

    a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_cond) |=>
        hist == {$past(hist[IDX_W-2:0]), $past(upd_taken)});

    a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && upd_cond) |=> $stable(hist));

    a_r8_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && upd_cond) |=> $stable(ctrs));
endmodule

bind gshare_predictor gshare_predictor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_cond   (upd_cond),
    .upd_taken  (upd_taken),
    .upd_idx    (upd_idx),
    .pred_idx   (pred_idx),
    .pred_taken (pred_taken),
    .hist       (hist_q),
    .ctrs       (ctr_all)
);

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [5:0]  pred_idx;
    logic        upd_valid = 1'b0;
    logic        upd_cond = 1'b0;
    logic        upd_taken = 1'b0;
    logic [5:0]  upd_idx = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] idx;
        logic       tk;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model
    logic [1:0] m_ctr [64];
    logic [5:0] m_hist;

    always #10 clk = ~clk;  // 50 MHz

    gshare_predictor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .pred_taken (pred_taken),
        .pred_idx   (pred_idx),
        .upd_valid  (upd_valid),
        .upd_cond   (upd_cond),
        .upd_taken  (upd_taken),
        .upd_idx    (upd_idx)
    );

    function automatic logic [31:0] pc_for(input logic [5:0] want_idx);
        return {24'h0010_00, want_idx ^ m_hist, 2'b00};
    endfunction

    // driver: one cycle of stimulus, expectation pushed from pre-update state (R9)
    task automatic step(input logic [31:0] pc, input logic uv, input logic uc,
                        input logic ut, input logic [5:0] ui, input string tag);
        exp_t e;
        @(negedge clk);
        fetch_pc  = pc;
        upd_valid = uv;
        upd_cond  = uc;
        upd_taken = ut;
        upd_idx   = ui;
        e.idx = pc[7:2] ^ m_hist;
        e.tk  = m_ctr[e.idx][1];
        e.tag = tag;
        exp_q.push_back(e);
        if (uv && uc) begin
            if (ut && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'b01;
            else if (!ut && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'b01;
            m_hist = {m_hist[4:0], ut};
        end
    endtask

    // monitor: compare just before the next rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #8;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                vectors++;
                if (pred_idx !== e.idx || pred_taken !== e.tk) begin
                    miscompares++;
                    $display("FAIL %s: idx=%0d taken=%0b expected idx=%0d taken=%0b",
                             e.tag, pred_idx, pred_taken, e.idx, e.tk);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [5:0]  tgt;
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state, every index predicts not taken
        for (int k = 0; k < 64; k++)
            step({24'h0, 6'(k), 2'b00}, 1'b0, 1'b0, 1'b0, 6'd0, "R1");
        step(32'hFFFF_FF03, 1'b0, 1'b0, 1'b0, 6'd0, "R2");

        // R4: drive entry 9 to saturation, observe via fetch
        for (int k = 0; k < 5; k++)
            step(pc_for(6'd0), 1'b1, 1'b1, 1'b1, 6'd9, "R4");
        step(pc_for(6'd9), 1'b0, 1'b0, 1'b0, 6'd0, "R4");

        // R5: drive entry 9 down to zero and beyond
        for (int k = 0; k < 2; k++)
            step(pc_for(6'd9), 1'b1, 1'b1, 1'b0, 6'd9, "R5");
        step(pc_for(6'd9), 1'b0, 1'b0, 1'b0, 6'd0, "R5");
        for (int k = 0; k < 3; k++)
            step(pc_for(6'd9), 1'b1, 1'b1, 1'b0, 6'd9, "R5");
        step(pc_for(6'd9), 1'b1, 1'b1, 1'b1, 6'd9, "R5");
        step(pc_for(6'd9), 1'b0, 1'b0, 1'b0, 6'd0, "R5");

        // R7: history shifting, oldest bit falls off
        for (int k = 0; k < 8; k++)
            step(32'h0000_0000, 1'b1, 1'b1, k[0] ^ k[2], 6'd40, "R7");
        step(32'h0000_00FC, 1'b0, 1'b0, 1'b0, 6'd0, "R7");

        // R8: non-conditional and invalid updates leave state alone
        tgt = 6'd40;
        for (int k = 0; k < 4; k++)
            step(pc_for(tgt), 1'b1, 1'b0, 1'b1, tgt, "R8");
        for (int k = 0; k < 4; k++)
            step(pc_for(tgt), 1'b0, 1'b1, 1'b0, tgt, "R8");
        step(pc_for(tgt), 1'b0, 1'b0, 1'b0, 6'd0, "R8");

        // R9: fetch hits the entry being updated in that cycle
        tgt = 6'd17;
        step(pc_for(tgt), 1'b1, 1'b1, 1'b1, tgt, "R9");
        step(pc_for(tgt), 1'b1, 1'b1, 1'b1, tgt, "R9");
        step(pc_for(tgt), 1'b0, 1'b0, 1'b0, 6'd0, "R9");

        // R6: update lands on upd_idx, not on the fetched entry
        step(pc_for(6'd3), 1'b1, 1'b1, 1'b1, 6'd50, "R6");
        step(pc_for(6'd3), 1'b1, 1'b1, 1'b1, 6'd50, "R6");
        step(pc_for(6'd3), 1'b0, 1'b0, 1'b0, 6'd0, "R6");
        step(pc_for(6'd50), 1'b0, 1'b0, 1'b0, 6'd0, "R6");

        // mixed traffic: R2 R3 R4 R5 R7 R8 together
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr, lfsr[3], lfsr[9] | lfsr[10], lfsr[5], lfsr[17:12], "R3 mix");
        end

        step(32'h0, 1'b0, 1'b0, 1'b0, 6'd0, "R3");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule